// File: doc/BRIEF.md
# Sequential Prefetch Stream Buffer

This block sits next to an instruction or data cache. It does the same job for both. When the cache misses, the block does two things. It fetches the missing block from next-level memory and returns it to the cache. It then also requests the block that follows it in address order. That second block is kept in a one-entry side buffer and is never written into the cache.

Every later miss first compares its address against the side buffer.

- If the buffer holds the requested block, the block is handed to the cache at once. The stream then moves forward by one block.
- If the requested block is the one still in flight from memory, the miss waits for that fill and no second request is sent.
- If the address does not match, the buffered block is thrown away. The demand block is fetched, and the stream restarts just after it.

Addresses are block addresses. Next-level memory answers requests in the order it accepts them.

Top module: `stream_prefetch_buffer`

## Requirements
- R1: Coming out of reset, `miss_ready` is 1, `mem_req_valid` is 0 and `resp_valid` is 0.
- R2: A miss when no stream exists sends two memory requests in order: first the miss address A, then A+1.
- R3: Each response carries the block address of its miss on `resp_addr`. It carries the data memory returned for that address on `resp_data`.
- R4: A miss that finds block A already stored in the side buffer gets its response in the cycle right after acceptance. No memory request is made for A. The next request issued is A+1.
- R5: A miss for the block whose prefetch is still in flight sends no request for it. It is answered when that fill returns, and A+1 is requested next.
- R6: A miss that matches neither the stored block nor the in-flight prefetch discards the side buffer. It then requests A, then A+1. A late fill of the old prefetch is dropped, so a later miss to the old prefetched address goes to memory again.
- R7: Block addresses wrap modulo 2^ABITS: the block after the highest address is block 0.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid with an unchanged address on the next cycle.
- R9: Exactly one response, one cycle wide, is given per accepted miss. `resp_valid` is never raised without an outstanding miss.
- R10: `miss_ready` is 0 whenever the block drives a memory request, so a prefetch request is always sent before the next miss is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Cache presents a miss |
| miss_ready | output | 1 | Miss accepted this cycle when valid |
| miss_addr | input | ABITS | Block address of the miss |
| resp_valid | output | 1 | Fill for the cache, one cycle |
| resp_addr | output | ABITS | Block address of the fill |
| resp_data | output | DBITS | Block data of the fill |
| mem_req_valid | output | 1 | Request to next-level memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ABITS | Requested block address |
| mem_rsp_valid | input | 1 | In-order memory data return |
| mem_rsp_data | input | DBITS | Returned block data |

## Verification
The bench covers these corner cases:

- **Back-to-back sequential misses that reach the prefetch while it is still in flight.** A design that ignored the pending fill would send a duplicate request. The in-order memory would then hand the cache the wrong block.
- **A non-matching miss while the prefetch is outstanding.** A design that did not drop the late fill would load stale data into the buffer or return it as the demand block.
- **A return to an address that was flushed.** A design that kept a stale valid entry would answer without going to memory.
- **The wrap from the highest block address to zero.** A design that got this wrong would prefetch a block that is never hit.
- **Memory that stalls `mem_req_ready`.** A design that moved its request address under back-pressure would fetch the wrong block.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,     // waiting for a miss; may send or receive the prefetch
    ST_DEM_REQ,  // demand request driven to memory
    ST_DEM_WAIT, // demand data awaited
    ST_DRAIN,    // stale prefetch data awaited and discarded
    ST_PF_WAIT   // miss waits on the in-flight prefetch
  } sbp_state_t;
endpackage

// File: rtl/sbp_entry.sv
module sbp_entry #(
  parameter int ABITS = 10,
  parameter int DBITS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load_tag,
  input  logic [ABITS-1:0] new_tag,
  input  logic             fill,
  input  logic [DBITS-1:0] fill_data,
  input  logic [ABITS-1:0] probe_addr,
  output logic [ABITS-1:0] tag,
  output logic [DBITS-1:0] data,
  output logic             valid,
  output logic             tag_match
);
  logic [ABITS-1:0] tag_q;
  logic [DBITS-1:0] data_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (clear)    valid_q <= 1'b0;
      if (fill)     valid_q <= 1'b1;
      if (load_tag) tag_q   <= new_tag;
    end
  end

  // data storage carries no reset so it maps onto plain registers or RAM
  always_ff @(posedge clk) begin
    if (fill) data_q <= fill_data;
  end

  assign tag       = tag_q;
  assign data      = data_q;
  assign valid     = valid_q;
  assign tag_match = (tag_q == probe_addr);
endmodule

// File: rtl/sbp_ctrl.sv
module sbp_ctrl
  import sbp_pkg::*;
#(
  parameter int ABITS = 10,
  parameter int DBITS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             miss_valid,
  output logic             miss_ready,
  input  logic [ABITS-1:0] miss_addr,
  output logic             resp_valid,
  output logic [ABITS-1:0] resp_addr,
  output logic [DBITS-1:0] resp_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [ABITS-1:0] mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [DBITS-1:0] mem_rsp_data,
  input  logic [ABITS-1:0] sb_tag,
  input  logic [DBITS-1:0] sb_data,
  input  logic             sb_valid,
  input  logic             sb_match,
  output logic             ent_clear,
  output logic             ent_load_tag,
  output logic [ABITS-1:0] ent_new_tag,
  output logic             ent_fill
);
  sbp_state_t       state_q;
  logic             pf_issue_q;  // prefetch request not yet accepted
  logic             pf_wait_q;   // prefetch accepted, data not yet back
  logic [ABITS-1:0] dem_addr_q;
  logic             resp_valid_q;
  logic [ABITS-1:0] resp_addr_q;
  logic [DBITS-1:0] resp_data_q;

  logic accept, buf_hit, pend_hit, idle, rsp_dem, rsp_pf;

  assign idle       = (state_q == ST_IDLE);
  assign miss_ready = idle && !pf_issue_q && !(pf_wait_q && mem_rsp_valid);
  assign accept     = miss_valid && miss_ready;
  assign buf_hit    = sb_valid && sb_match;
  assign pend_hit   = pf_wait_q && sb_match;
  assign rsp_dem    = (state_q == ST_DEM_WAIT) && mem_rsp_valid;
  assign rsp_pf     = (state_q == ST_PF_WAIT) && mem_rsp_valid;

  assign mem_req_valid = (state_q == ST_DEM_REQ) || (idle && pf_issue_q);
  assign mem_req_addr  = (state_q == ST_DEM_REQ) ? dem_addr_q : sb_tag;

  always_comb begin
    ent_clear    = accept;
    ent_fill     = idle && pf_wait_q && mem_rsp_valid;
    ent_load_tag = 1'b0;
    ent_new_tag  = sb_tag + 1'b1;
    if (accept && buf_hit) begin
      ent_load_tag = 1'b1;
      ent_new_tag  = miss_addr + 1'b1;
    end else if (rsp_dem) begin
      ent_load_tag = 1'b1;
      ent_new_tag  = dem_addr_q + 1'b1;
    end else if (rsp_pf) begin
      ent_load_tag = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      pf_issue_q   <= 1'b0;
      pf_wait_q    <= 1'b0;
      dem_addr_q   <= '0;
      resp_valid_q <= 1'b0;
      resp_addr_q  <= '0;
      resp_data_q  <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (pf_issue_q && mem_req_ready) begin
            pf_issue_q <= 1'b0;
            pf_wait_q  <= 1'b1;
          end
          if (pf_wait_q && mem_rsp_valid) pf_wait_q <= 1'b0;
          if (accept) begin
            if (buf_hit) begin
              resp_valid_q <= 1'b1;
              resp_addr_q  <= miss_addr;
              resp_data_q  <= sb_data;
              pf_issue_q   <= 1'b1;
            end else if (pend_hit) begin
              state_q <= ST_PF_WAIT;
            end else begin
              dem_addr_q <= miss_addr;
              state_q    <= pf_wait_q ? ST_DRAIN : ST_DEM_REQ;
            end
          end
        end
        ST_DRAIN: begin
          if (mem_rsp_valid) begin
            pf_wait_q <= 1'b0;
            state_q   <= ST_DEM_REQ;
          end
        end
        ST_DEM_REQ: begin
          if (mem_req_ready) state_q <= ST_DEM_WAIT;
        end
        ST_DEM_WAIT: begin
          if (mem_rsp_valid) begin
            resp_valid_q <= 1'b1;
            resp_addr_q  <= dem_addr_q;
            resp_data_q  <= mem_rsp_data;
            pf_issue_q   <= 1'b1;
            state_q      <= ST_IDLE;
          end
        end
        ST_PF_WAIT: begin
          if (mem_rsp_valid) begin
            resp_valid_q <= 1'b1;
            resp_addr_q  <= sb_tag;
            resp_data_q  <= mem_rsp_data;
            pf_wait_q    <= 1'b0;
            pf_issue_q   <= 1'b1;
            state_q      <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_addr  = resp_addr_q;
  assign resp_data  = resp_data_q;
endmodule

// File: rtl/stream_prefetch_buffer.sv
module stream_prefetch_buffer #(
  parameter int ABITS = 10,
  parameter int DBITS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             miss_valid,
  output logic             miss_ready,
  input  logic [ABITS-1:0] miss_addr,
  output logic             resp_valid,
  output logic [ABITS-1:0] resp_addr,
  output logic [DBITS-1:0] resp_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [ABITS-1:0] mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [DBITS-1:0] mem_rsp_data
);
  logic [ABITS-1:0] ent_tag, ent_new_tag;
  logic [DBITS-1:0] ent_data;
  logic             ent_valid, ent_match, ent_clear, ent_load_tag, ent_fill;

  sbp_entry #(.ABITS(ABITS), .DBITS(DBITS)) u_entry (
    .clk        (clk),
    .rst        (rst),
    .clear      (ent_clear),
    .load_tag   (ent_load_tag),
    .new_tag    (ent_new_tag),
    .fill       (ent_fill),
    .fill_data  (mem_rsp_data),
    .probe_addr (miss_addr),
    .tag        (ent_tag),
    .data       (ent_data),
    .valid      (ent_valid),
    .tag_match  (ent_match)
  );

  sbp_ctrl #(.ABITS(ABITS), .DBITS(DBITS)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .miss_addr     (miss_addr),
    .resp_valid    (resp_valid),
    .resp_addr     (resp_addr),
    .resp_data     (resp_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .sb_tag        (ent_tag),
    .sb_data       (ent_data),
    .sb_valid      (ent_valid),
    .sb_match      (ent_match),
    .ent_clear     (ent_clear),
    .ent_load_tag  (ent_load_tag),
    .ent_new_tag   (ent_new_tag),
    .ent_fill      (ent_fill)
  );
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
  parameter int ABITS = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             miss_valid,
  input logic             miss_ready,
  input logic [ABITS-1:0] miss_addr,
  input logic             resp_valid,
  input logic [ABITS-1:0] resp_addr,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [ABITS-1:0] mem_req_addr,
  input logic             sb_valid,
  input logic             sb_match
);
  logic rst_q = 1'b0;

  always @(posedge clk) begin
    if (rst_q) begin
      p_reset_idle_r1: assert (miss_ready && !mem_req_valid && !resp_valid)
        else $error("R1 outputs not idle after reset");
    end
    rst_q <= rst;
  end

  // R4: a stored block answers on the very next cycle
  p_hit_next_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    miss_valid && miss_ready && sb_valid && sb_match
      |=> resp_valid && resp_addr == $past(miss_addr));

  // R8: request held under back-pressure
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R9: response is a single-cycle pulse
  p_resp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R10: no miss taken while a request is on the memory port
  p_ready_no_req_r10: assert property (@(posedge clk) disable iff (rst)
    miss_ready |-> !mem_req_valid);
endmodule

bind stream_prefetch_buffer sbp_checker #(.ABITS(ABITS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .miss_valid    (miss_valid),
  .miss_ready    (miss_ready),
  .miss_addr     (miss_addr),
  .resp_valid    (resp_valid),
  .resp_addr     (resp_addr),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .sb_valid      (ent_valid),
  .sb_match      (ent_match)
);

// File: tb/stream_prefetch_buffer_tb.sv
module stream_prefetch_buffer_tb;
  localparam int ABITS = 10;
  localparam int DBITS = 32;
  localparam int AMASK = (1 << ABITS) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             miss_valid = 1'b0;
  logic             miss_ready;
  logic [ABITS-1:0] miss_addr = '0;
  logic             resp_valid;
  logic [ABITS-1:0] resp_addr;
  logic [DBITS-1:0] resp_data;
  logic             mem_req_valid;
  logic             mem_req_ready = 1'b0;
  logic [ABITS-1:0] mem_req_addr;
  logic             mem_rsp_valid = 1'b0;
  logic [DBITS-1:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  stream_prefetch_buffer #(.ABITS(ABITS), .DBITS(DBITS)) u_dut (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
    .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_data(resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0, running = 1'b0;
  int    mq[$];          // requests accepted by the memory model
  int    exp_req[$];     // requests the model predicts
  string exp_tag[$];
  int    lat = 2, wait_cnt = 0;
  bit    rdy_rand = 1'b0;
  bit    hs_pend = 1'b0, rsp_pend = 1'b0, prev_stall = 1'b0;
  int    hs_addr = 0, prev_addr = 0;
  int    acc_cnt = 0, resp_cnt = 0;
  bit    have_stream = 1'b0;
  int    sb_next = 0;

  function automatic logic [DBITS-1:0] blk_data(int a);
    return DBITS'(a * 32'h9E3779B9) ^ 32'h5A5A1234;
  endfunction

  task automatic chk(bit ok, string rq, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // memory model and per-cycle comparisons
  always @(negedge clk) begin
    if (hs_pend) mq.push_back(hs_addr);
    if (rsp_pend) begin void'(mq.pop_front()); wait_cnt = 0; end
    if (mq.size() > 0 && wait_cnt >= lat) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = blk_data(mq[0]);
    end else begin
      mem_rsp_valid = 1'b0;
      if (mq.size() > 0) wait_cnt++;
    end
    mem_req_ready = rdy_rand ? 1'($urandom_range(0, 1)) : 1'b1;
    #1;
    hs_pend  = running && mem_req_valid && mem_req_ready;
    hs_addr  = int'(mem_req_addr);
    rsp_pend = mem_rsp_valid;
    if (running) begin
      if (hs_pend) begin
        if (exp_req.size() == 0) chk(1'b0, "R2 unexpected request", hs_addr, -1);
        else begin
          string t;
          int    e;
          e = exp_req.pop_front();
          t = exp_tag.pop_front();
          chk(hs_addr == e, t, hs_addr, e);
        end
      end
      chk(!(miss_ready && mem_req_valid), "R10", mem_req_valid, 0);
      if (prev_stall) chk(mem_req_valid && int'(mem_req_addr) == prev_addr, "R8",
                          mem_req_addr, prev_addr);
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = int'(mem_req_addr);
      if (resp_valid) begin
        chk(resp_cnt < acc_cnt, "R9", resp_cnt, acc_cnt);
        resp_cnt++;
      end
    end
  end

  task automatic do_miss(int a);
    bit fast, match;
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = ABITS'(a);
    #2;
    while (!miss_ready) begin @(negedge clk); #2; end
    match = have_stream && (sb_next == a);
    fast  = match && (mq.size() == 0);
    if (!match) begin
      exp_req.push_back(a);
      exp_tag.push_back(have_stream ? "R6" : "R2");
    end
    exp_req.push_back((a + 1) & AMASK);
    exp_tag.push_back(((a & AMASK) == AMASK) ? "R7" : (match ? (fast ? "R4" : "R5") : "R2"));
    have_stream = 1'b1;
    sb_next     = (a + 1) & AMASK;
    acc_cnt++;
    @(negedge clk);
    miss_valid = 1'b0;
    #2;
    if (fast) chk(resp_valid == 1'b1, "R4 late hit", resp_valid, 1);
    while (!resp_valid) begin @(negedge clk); #2; end
    chk(int'(resp_addr) == a, "R3 addr", resp_addr, a);
    chk(resp_data == blk_data(a), "R3 data", resp_data, blk_data(a));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    chk(miss_ready == 1'b1, "R1 ready", miss_ready, 1);
    chk(mem_req_valid == 1'b0, "R1 req", mem_req_valid, 0);
    chk(resp_valid == 1'b0, "R1 resp", resp_valid, 0);
    running = 1'b1;

    // R5: back-to-back sequential misses catch the prefetch in flight
    lat = 3;
    for (int i = 10; i < 18; i++) do_miss(i);
    // R4: spaced misses find the block already stored
    idle(10);
    for (int i = 40; i < 46; i++) begin do_miss(i); idle(12); end
    // R6: flush with the stored block, then revisit it
    do_miss(100); idle(10); do_miss(101); idle(10);
    do_miss(300); idle(10); do_miss(102); idle(10);
    // R6: flush while the prefetch is still in flight
    lat = 8;
    do_miss(500); do_miss(700); do_miss(701); idle(20);
    // R7: wrap from the top block to zero
    lat = 2;
    do_miss(AMASK - 1); idle(8); do_miss(AMASK); idle(8); do_miss(0); idle(8);
    // R8: stalled memory with mixed patterns
    rdy_rand = 1'b1;
    for (int i = 0; i < 60; i++) begin
      lat = $urandom_range(0, 5);
      if ($urandom_range(0, 2) != 0) do_miss(sb_next);
      else do_miss($urandom_range(0, 31));
      idle($urandom_range(0, 6));
    end
    rdy_rand = 1'b0;
    idle(40);
    chk(exp_req.size() == 0, "R2 missing request", exp_req.size(), 0);
    chk(mq.size() == 0, "R9 stuck memory", mq.size(), 0);
    chk(resp_cnt == acc_cnt, "R9 count", resp_cnt, acc_cnt);
    finish_run();
  end
endmodule